// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Core

This block is a 32-bit up-counting timer that sits behind a simple single-cycle register bus. Software loads a starting value and a reload value, picks a tick rate, and starts the count. The counter advances either on every clock or, with the prescaler turned on, once every 2^(PTV+1) clocks. When the counter passes all-ones it is loaded from the reload register. In repeating mode it keeps running. In one-shot mode it halts by clearing its own start bit.

Every overflow bumps a 24-bit event counter and sets a sticky status flag. Two other sticky flags are set by one-cycle pulses from neighbouring blocks: a compare unit reports matches and a capture unit reports captured edges. A level interrupt is raised while any flag is pending and its enable bit is set. Flags are cleared by writing 1 to them. The block exports a tick strobe and an overflow strobe so that the compare and capture blocks can follow the count. A self-clearing soft reset returns every register to its reset value.

Top module: `tmr_core`

## Requirements
- R1: After `rst_n` is released, every register reads 0, the reset-done bit reads 1 and `irq` is 0.
- R2: Control bit 0 is the start bit. While it is 1 and the prescaler is off, the counter adds one on every clock. While it is 0, the counter holds its value.
- R3: When prescaler-enable control bit 5 is 1, the counter advances once every 2^(PTV+1) clocks, with PTV taken from control bits 4:2. For example, PTV=3 gives one step per 16 clocks, and the first step comes 16 clocks after the start.
- R4: With control bit 1 set to 1 (repeat mode), a step from all-ones loads the reload register and the counter keeps running.
- R5: With control bit 1 set to 0 (one-shot mode), a step from all-ones loads the reload register and clears the start bit, unless the control register is written in that same cycle.
- R6: The 24-bit overflow count at 0x54 adds one for each overflow, wraps from 0xFFFFFF to 0, is writable, and keeps only its low 24 bits.
- R7: The status register at 0x18 holds match (bit 0, set by `evt_match`), overflow (bit 1) and capture (bit 2, set by `evt_capture`). Writing 1 to a bit clears it and writing 0 leaves it unchanged. When an event and a clear hit the same bit in the same cycle, the event wins.
- R8: The enable register at 0x1C uses the same bit positions. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R9: A write to the counter at 0x28 sets the count at the next clock edge and overrides any step in that cycle. It also restarts the prescaler phase, so the next step comes a full 2^(PTV+1) clocks later.
- R10: Writing 1 to bit 1 at 0x10 starts a soft reset. For one cycle the reset-done bit (bit 0 at 0x14) reads 0. At the following edge every register returns to its R1 value. Bit 1 at 0x10 always reads 0.
- R11: The register map is: control 0x24, counter 0x28, reload 0x2C, status 0x18, enable 0x1C, overflow count 0x54, soft-reset control 0x10, reset status 0x14. Unused bits and unmapped addresses read 0. `bus_rdata` is 0 when `bus_sel` is 0.
- R12: `tick_stb` is 1 in each cycle whose clock edge advances the counter. `ovf_stb` is 1 in the cycle whose edge takes the counter past all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_match | input | 1 | One-cycle match pulse from the compare block |
| evt_capture | input | 1 | One-cycle capture pulse from the capture block |
| irq | output | 1 | Level interrupt |
| tick_stb | output | 1 | The counter advances at this edge |
| ovf_stb | output | 1 | The counter overflows at this edge |

## Verification
The overflow flag can be set by the counter in the same cycle that software writes 1 to clear it. The bench provokes this by loading all-ones into a stopped counter and writing the start bit. It then issues the write-one-to-clear of the overflow flag on the very next clock, which is the edge where the overflow occurs. The flag must still read 1 afterwards, and a later clear with no overflow pending must bring it to 0. A second collision, a counter write landing on a prescaler tick, is judged by reading the exact written value back and timing the next step from the restarted phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Register byte offsets; software drivers decode these
   localparam int OFS_SYSCFG  = 'h10;
   localparam int OFS_SYSSTAT = 'h14;
   localparam int OFS_FLAGS   = 'h18;
   localparam int OFS_IEN     = 'h1C;
   localparam int OFS_CTRL    = 'h24;
   localparam int OFS_CNT     = 'h28;
   localparam int OFS_RELOAD  = 'h2C;
   localparam int OFS_OVC     = 'h54;

   // Field positions
   localparam int SRST_BIT = 1;
   localparam int DONE_BIT = 0;
   localparam int CTL_RUN  = 0;
   localparam int CTL_AR   = 1;
   localparam int CTL_PTV  = 2;

   localparam int FLG_MATCH = 0;
   localparam int FLG_OVF   = 1;
   localparam int FLG_CAPT  = 2;
   localparam int FLG_W     = 3;

   typedef logic [FLG_W-1:0] flag_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PTV_W         = 3,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             run,
   input  logic             pre_en,
   input  logic [PTV_W-1:0] ptv,
   input  logic             restart,
   output logic             tick
);
   localparam int PH_W = 2 ** PTV_W;

   generate
      if (HAS_PRESCALER) begin : g_div
         logic [PH_W-1:0] phase_q;
         logic [PH_W-1:0] lim;
         logic            at_lim;

         // terminal phase is 2^(ptv+1)-1
         assign lim    = {PH_W{1'b1}} >> (PTV_W'(PH_W - 1) - ptv);
         assign at_lim = (phase_q == lim);
         assign tick   = run & (~pre_en | at_lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (srst || !run || restart || !pre_en || at_lim) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
      end else begin : g_direct
         logic unused_ps;
         assign unused_ps = ^{clk, rst_n, srst, pre_en, ptv, restart};
         assign tick      = run;
      end
   endgenerate
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 32,
   parameter int OVC_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic             ovc_wr,
   input  logic [31:0]      wdata,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic [OVC_W-1:0] ovc,
   output logic             adv,
   output logic             ovf
);
   logic [CNT_W-1:0] cnt_q;
   logic [OVC_W-1:0] ovc_q;

   // a software write to the counter overrides a pending step
   assign adv = tick & ~cnt_wr;
   assign ovf = adv & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (srst) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= wdata[CNT_W-1:0];
      end else if (ovf) begin
         cnt_q <= reload;
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovc_q <= '0;
      end else if (srst) begin
         ovc_q <= '0;
      end else if (ovc_wr) begin
         ovc_q <= wdata[OVC_W-1:0];
      end else if (ovf) begin
         ovc_q <= ovc_q + 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign ovc = ovc_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int CNT_W         = 32,
   parameter int OVC_W         = 24,
   parameter int PTV_W         = 3,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              evt_match,
   input  logic              evt_capture,
   input  logic              ovf,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [OVC_W-1:0]  ovc,
   output logic              run,
   output logic              ar,
   output logic              pre_en,
   output logic [PTV_W-1:0]  ptv,
   output logic [CNT_W-1:0]  reload,
   output logic              srst,
   output logic              cnt_wr,
   output logic              ovc_wr,
   output logic              ctrl_wr,
   output flag_t             flags,
   output logic              irq
);
   localparam int CTL_PRE = CTL_PTV + PTV_W;
   localparam int CTL_W   = CTL_PRE + 1;
   localparam logic [CTL_W-1:0] CTL_MASK =
      HAS_PRESCALER ? {CTL_W{1'b1}} : {1'b0, {(CTL_W-1){1'b1}}};

   logic [CTL_W-1:0] ctrl_q;
   logic [CNT_W-1:0] reload_q;
   flag_t            flags_q, ien_q, flg_set, flg_clr;
   logic             srst_q;
   logic             wr, hit_sys, hit_flags, hit_ien, hit_reload;

   assign wr         = bus_sel & bus_wr;
   assign hit_sys    = wr & (bus_addr == ADDR_W'(OFS_SYSCFG));
   assign hit_flags  = wr & (bus_addr == ADDR_W'(OFS_FLAGS));
   assign hit_ien    = wr & (bus_addr == ADDR_W'(OFS_IEN));
   assign hit_reload = wr & (bus_addr == ADDR_W'(OFS_RELOAD));
   assign ctrl_wr    = wr & (bus_addr == ADDR_W'(OFS_CTRL));
   assign cnt_wr     = wr & (bus_addr == ADDR_W'(OFS_CNT));
   assign ovc_wr     = wr & (bus_addr == ADDR_W'(OFS_OVC));

   // one-cycle soft reset pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= hit_sys & bus_wdata[SRST_BIT] & ~srst_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (srst_q) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= bus_wdata[CTL_W-1:0] & CTL_MASK;
      end else if (ovf && !ctrl_q[CTL_AR]) begin
         ctrl_q[CTL_RUN] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         ien_q    <= '0;
      end else if (srst_q) begin
         reload_q <= '0;
         ien_q    <= '0;
      end else begin
         if (hit_reload) reload_q <= bus_wdata[CNT_W-1:0];
         if (hit_ien)    ien_q    <= bus_wdata[FLG_W-1:0];
      end
   end

   always_comb begin
      flg_set            = '0;
      flg_set[FLG_MATCH] = evt_match;
      flg_set[FLG_OVF]   = ovf;
      flg_set[FLG_CAPT]  = evt_capture;
      flg_clr            = hit_flags ? bus_wdata[FLG_W-1:0] : '0;
   end

   // an event in the clearing cycle survives the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags_q <= '0;
      else if (srst_q) flags_q <= '0;
      else             flags_q <= (flags_q & ~flg_clr) | flg_set;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            ADDR_W'(OFS_SYSSTAT): bus_rdata[DONE_BIT]    = ~srst_q;
            ADDR_W'(OFS_FLAGS):   bus_rdata[FLG_W-1:0]   = flags_q;
            ADDR_W'(OFS_IEN):     bus_rdata[FLG_W-1:0]   = ien_q;
            ADDR_W'(OFS_CTRL):    bus_rdata[CTL_W-1:0]   = ctrl_q;
            ADDR_W'(OFS_CNT):     bus_rdata[CNT_W-1:0]   = cnt;
            ADDR_W'(OFS_RELOAD):  bus_rdata[CNT_W-1:0]   = reload_q;
            ADDR_W'(OFS_OVC):     bus_rdata[OVC_W-1:0]   = ovc;
            default:              bus_rdata              = '0;
         endcase
      end
   end

   assign run    = ctrl_q[CTL_RUN];
   assign ar     = ctrl_q[CTL_AR];
   assign ptv    = ctrl_q[CTL_PTV +: PTV_W];
   assign pre_en = ctrl_q[CTL_PRE];
   assign reload = reload_q;
   assign srst   = srst_q;
   assign flags  = flags_q;
   assign irq    = |(flags_q & ien_q);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int CNT_W         = 32,
   parameter int OVC_W         = 24,
   parameter int PTV_W         = 3,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              evt_match,
   input  logic              evt_capture,
   output logic              irq,
   output logic              tick_stb,
   output logic              ovf_stb
);
   localparam int CTL_W = CTL_PTV + PTV_W + 1;

   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_addr
      $error("tmr_core: ADDR_W must lie in 7..16");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("tmr_core: CNT_W must lie in 2..32");
   end
   if (OVC_W < 1 || OVC_W > 32) begin : g_bad_ovc
      $error("tmr_core: OVC_W must lie in 1..32");
   end
   if (PTV_W < 1 || PTV_W > 4 || CTL_W > 32) begin : g_bad_ptv
      $error("tmr_core: PTV_W must lie in 1..4");
   end

   logic             run, ar, pre_en, srst;
   logic             cnt_wr, ovc_wr, ctrl_wr;
   logic [PTV_W-1:0] ptv;
   logic [CNT_W-1:0] cnt, reload;
   logic [OVC_W-1:0] ovc;
   logic             tick_raw;
   flag_t            flags;

   tmr_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OVC_W(OVC_W),
      .PTV_W(PTV_W), .HAS_PRESCALER(HAS_PRESCALER)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .evt_match  (evt_match),
      .evt_capture(evt_capture),
      .ovf        (ovf_stb),
      .cnt        (cnt),
      .ovc        (ovc),
      .run        (run),
      .ar         (ar),
      .pre_en     (pre_en),
      .ptv        (ptv),
      .reload     (reload),
      .srst       (srst),
      .cnt_wr     (cnt_wr),
      .ovc_wr     (ovc_wr),
      .ctrl_wr    (ctrl_wr),
      .flags      (flags),
      .irq        (irq)
   );

   tmr_prescale #(
      .PTV_W(PTV_W), .HAS_PRESCALER(HAS_PRESCALER)
   ) u_ps (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst),
      .run    (run),
      .pre_en (pre_en),
      .ptv    (ptv),
      .restart(cnt_wr),
      .tick   (tick_raw)
   );

   tmr_count #(
      .CNT_W(CNT_W), .OVC_W(OVC_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst),
      .tick  (tick_raw),
      .cnt_wr(cnt_wr),
      .ovc_wr(ovc_wr),
      .wdata (bus_wdata),
      .reload(reload),
      .cnt   (cnt),
      .ovc   (ovc),
      .adv   (tick_stb),
      .ovf   (ovf_stb)
   );
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int OVC_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srst,
   input logic             run,
   input logic             ar,
   input logic             ctrl_wr,
   input logic             cnt_wr,
   input logic             ovc_wr,
   input logic             tick_stb,
   input logic             ovf_stb,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic [OVC_W-1:0] ovc,
   input flag_t            flags
);
   AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (tick_stb && !ovf_stb) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (!run && !cnt_wr) |=> $stable(cnt)); // R2

   AST_OVF_RELOADS: assert property (@(posedge clk) disable iff (!rst_n || srst)
      ovf_stb |=> cnt == $past(reload)); // R4

   AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (ovf_stb && !ar && !ctrl_wr) |=> !run); // R5

   AST_OVC_COUNTS: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (ovf_stb && !ovc_wr) |=> ovc == OVC_W'($past(ovc) + 1'b1)); // R6

   AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n || srst)
      ovf_stb |=> flags[FLG_OVF]); // R7

   AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (cnt == '0 && !run && flags == '0 && ovc == '0)); // R10

   AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tick_stb |-> run); // R12
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W), .OVC_W(OVC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .srst    (srst),
   .run     (run),
   .ar      (ar),
   .ctrl_wr (ctrl_wr),
   .cnt_wr  (cnt_wr),
   .ovc_wr  (ovc_wr),
   .tick_stb(tick_stb),
   .ovf_stb (ovf_stb),
   .cnt     (cnt),
   .reload  (reload),
   .ovc     (ovc),
   .flags   (flags)
);

// File: tb/sim_tmr_core.sv
`timescale 1ns/1ps
module sim_tmr_core;
   localparam logic [7:0] A_SYSCFG = 8'h10, A_SYSSTAT = 8'h14, A_FLAGS = 8'h18,
                          A_IEN = 8'h1C, A_CTRL = 8'h24, A_CNT = 8'h28,
                          A_RELOAD = 8'h2C, A_OVC = 8'h54;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        evt_match = 1'b0, evt_capture = 1'b0;
   logic        irq, tick_stb, ovf_stb;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tmr_core u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_match(evt_match), .evt_capture(evt_capture),
      .irq(irq), .tick_stb(tick_stb), .ovf_stb(ovf_stb)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd_reg(a, v);
      check(req, v, exp);
   endtask

   task automatic pulse(input bit is_match);
      if (is_match) evt_match = 1'b1; else evt_capture = 1'b1;
      @(posedge clk);
      @(negedge clk);
      evt_match = 1'b0; evt_capture = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // bench reference: n clock edges after the start bit was written
   function automatic void model(input logic [31:0] st, input logic [31:0] rl,
                                 input bit ar, input bit pre, input int ptv, input int n,
                                 output logic [31:0] c, output int ov, output bit rn);
      int ph = 0;
      int lim = (1 << (ptv + 1)) - 1;
      bit tk;
      c = st; ov = 0; rn = 1'b1;
      for (int i = 0; i < n; i++) begin
         if (!rn) break;
         tk = pre ? (ph == lim) : 1'b1;
         ph = (pre && !tk) ? ph + 1 : 0;
         if (tk) begin
            if (c == 32'hFFFF_FFFF) begin
               c = rl; ov++;
               if (!ar) rn = 1'b0;
            end else begin
               c = c + 1;
            end
         end
      end
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int unused_seed;
      unused_seed = $urandom(32'd4242);
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      expect_reg("R1 ctrl", A_CTRL, 0);
      expect_reg("R1 cnt", A_CNT, 0);
      expect_reg("R1 reload", A_RELOAD, 0);
      expect_reg("R1 flags", A_FLAGS, 0);
      expect_reg("R1 ien", A_IEN, 0);
      expect_reg("R1 ovc", A_OVC, 0);
      expect_reg("R1 done", A_SYSSTAT, 1);
      check("R1 irq", {31'b0, irq}, 0);

      // R11 unused bits and unmapped address
      wr_reg(A_CTRL, 32'hFFFF_FFFE);
      expect_reg("R11 ctrl mask", A_CTRL, 32'h3E);
      wr_reg(A_CTRL, 0);
      wr_reg(A_OVC, 32'hFFFF_FFFF);
      expect_reg("R11 ovc mask", A_OVC, 32'h00FF_FFFF);
      expect_reg("R11 unmapped", 8'h30, 0);
      wr_reg(A_OVC, 0);

      // R2 start, count, stop, hold
      wr_reg(A_CNT, 100);
      wr_reg(A_CTRL, 32'h1);
      idle(9);
      expect_reg("R2 running", A_CNT, 109);
      check("R12 tick while running", {31'b0, tick_stb}, 1);
      wr_reg(A_CTRL, 0);
      idle(5);
      expect_reg("R2 held", A_CNT, 110);
      check("R12 no tick stopped", {31'b0, tick_stb}, 0);

      // R3 prescaler PTV=3 -> 16 clocks per step
      wr_reg(A_CNT, 0);
      wr_reg(A_CTRL, 32'h2D);
      idle(15);
      expect_reg("R3 before step", A_CNT, 0);
      check("R12 tick at phase end", {31'b0, tick_stb}, 1);
      idle(1);
      expect_reg("R3 after step", A_CNT, 1);
      wr_reg(A_CTRL, 0);

      // R5 one-shot with R6 wrap
      wr_reg(A_RELOAD, 32'h55);
      wr_reg(A_CNT, 32'hFFFF_FFFE);
      wr_reg(A_FLAGS, 7);
      wr_reg(A_OVC, 32'h00FF_FFFF);
      wr_reg(A_CTRL, 32'h1);
      idle(1);
      check("R12 ovf strobe", {31'b0, ovf_stb}, 1);
      idle(1);
      expect_reg("R5 reload", A_CNT, 32'h55);
      expect_reg("R5 start cleared", A_CTRL, 0);
      expect_reg("R6 wrap", A_OVC, 0);
      expect_reg("R7 ovf flag", A_FLAGS, 2);
      idle(3);
      expect_reg("R5 halted", A_CNT, 32'h55);

      // R7 sticky flags, write-one-to-clear
      wr_reg(A_FLAGS, 7);
      pulse(1'b1);
      expect_reg("R7 match", A_FLAGS, 1);
      pulse(1'b0);
      expect_reg("R7 capture", A_FLAGS, 5);
      wr_reg(A_FLAGS, 0);
      expect_reg("R7 write zero", A_FLAGS, 5);
      wr_reg(A_FLAGS, 4);
      expect_reg("R7 clear capture", A_FLAGS, 1);

      // R8 interrupt masking
      wr_reg(A_IEN, 0);
      check("R8 masked", {31'b0, irq}, 0);
      wr_reg(A_IEN, 1);
      check("R8 enabled", {31'b0, irq}, 1);
      wr_reg(A_IEN, 6);
      check("R8 other enables", {31'b0, irq}, 0);
      wr_reg(A_FLAGS, 1);
      expect_reg("R7 clear match", A_FLAGS, 0);

      // R7 collision: overflow and clear on the same edge
      wr_reg(A_RELOAD, 0);
      wr_reg(A_CNT, 32'hFFFF_FFFF);
      wr_reg(A_CTRL, 32'h3);
      wr_reg(A_FLAGS, 2);
      expect_reg("R7 set beats clear", A_FLAGS, 2);
      wr_reg(A_FLAGS, 2);
      expect_reg("R7 later clear", A_FLAGS, 0);
      wr_reg(A_CTRL, 0);

      // R9 counter write overrides step
      wr_reg(A_CNT, 0);
      wr_reg(A_CTRL, 32'h1);
      wr_reg(A_CNT, 32'h1000);
      expect_reg("R9 exact write", A_CNT, 32'h1000);
      idle(1);
      expect_reg("R9 continues", A_CNT, 32'h1001);
      wr_reg(A_CTRL, 0);
      // R9 phase restart with PTV=1 (4 clocks)
      wr_reg(A_CNT, 0);
      wr_reg(A_CTRL, 32'h25);
      idle(1);
      wr_reg(A_CNT, 32'h20);
      idle(3);
      expect_reg("R9 phase restarted", A_CNT, 32'h20);
      idle(1);
      expect_reg("R9 first step", A_CNT, 32'h21);
      wr_reg(A_CTRL, 0);

      // R10 soft reset
      wr_reg(A_RELOAD, 9);
      wr_reg(A_IEN, 7);
      wr_reg(A_CTRL, 32'h3);
      pulse(1'b1);
      wr_reg(A_SYSCFG, 32'h2);
      expect_reg("R10 done low", A_SYSSTAT, 0);
      expect_reg("R10 bit reads 0", A_SYSCFG, 0);
      idle(1);
      expect_reg("R10 done high", A_SYSSTAT, 1);
      expect_reg("R10 ctrl", A_CTRL, 0);
      expect_reg("R10 cnt", A_CNT, 0);
      expect_reg("R10 reload", A_RELOAD, 0);
      expect_reg("R10 ien", A_IEN, 0);
      expect_reg("R10 flags", A_FLAGS, 0);
      check("R10 irq", {31'b0, irq}, 0);

      // random runs: R2 R3 R4 R5 R6 R8
      for (int t = 0; t < 30; t++) begin
         logic [31:0] st, rl, ec;
         bit ar, pre, ern;
         int ptv, n, eov;
         st  = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF - $urandom_range(0, 10) : $urandom;
         rl  = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF - $urandom_range(0, 20) : $urandom;
         ar  = 1'($urandom_range(0, 1));
         pre = 1'($urandom_range(0, 1));
         ptv = $urandom_range(0, 3);
         n   = $urandom_range(1, 120);
         wr_reg(A_CTRL, 0);
         wr_reg(A_CNT, st);
         wr_reg(A_RELOAD, rl);
         wr_reg(A_OVC, 0);
         wr_reg(A_FLAGS, 7);
         wr_reg(A_IEN, 2);
         wr_reg(A_CTRL, {26'b0, pre, 3'(ptv), ar, 1'b1});
         idle(n);
         model(st, rl, ar, pre, ptv, n, ec, eov, ern);
         expect_reg("R2/R3/R4 random count", A_CNT, ec);
         expect_reg("R6 random ovc", A_OVC, 32'(eov));
         rd_reg(A_CTRL, v);
         check("R5 random start bit", {31'b0, v[0]}, {31'b0, ern});
         check("R8 random irq", {31'b0, irq}, {31'b0, (eov > 0)});
      end
      wr_reg(A_CTRL, 0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule